// File: doc/BRIEF.md
# Serial Transmitter with Port-Level Line Override

This block is an asynchronous serial transmitter whose output line doubles as a general-purpose port bit. While the transmitter is switched on, it owns the line. When idle it holds the line at mark (1). A frame is a 0 start bit, eight data bits sent least significant bit first, an optional parity bit and one or two stop bits. Each bit lasts sixteen pulses of an external oversampling tick.

While the transmitter is switched off, it gives the line back to the port. The line level follows a port level bit, and the output enable follows a port direction bit. Software uses this to park the line high before switching the transmitter on. It also uses it to force a break: it first drops the port level to 0 and then switches the transmitter off.

Switching the transmitter off clears it at once, even partway through a frame. When it is switched on again, it starts from a clean bit boundary.

Top module: `brkx_uart_tx`

## Requirements
- R1: While `xmit_on` is 0, `line_o` equals `gp_level` and `line_oe` equals `gp_dir` in the same cycle.
- R2: While `xmit_on` is 1 and no frame is in flight, `line_o` is 1, `line_oe` is 1 and `byte_rdy` is 1.
- R3: While `xmit_on` is 0, `byte_rdy` is 0 and `byte_vld` is ignored. After switching on, the line stays at mark with no frame sent.
- R4: A byte is accepted on a clock edge where `byte_vld` and `byte_rdy` are both 1. From the next cycle the line carries the frame in this order: a start bit of 0, then `byte_dat[0]` through `byte_dat[7]`, then the optional parity bit, then the stop bits of 1.
- R5: Every frame bit lasts exactly 16 `os_tick` pulses counted while the frame is in flight. The line changes in the cycle after the 16th pulse.
- R6: With `par_on` = 1, a parity bit follows the data. It is the XOR of the eight data bits when `par_odd` = 0 (even parity), and the inverse of that XOR when `par_odd` = 1.
- R7: With `stop2` = 0 the frame has one stop bit; with `stop2` = 1 it has two. `byte_rdy` returns to 1 in the cycle after the last stop bit ends, giving frame lengths of 10 to 12 bits.
- R8: While a frame is in flight, `byte_rdy` is 0 and a `byte_vld` pulse has no effect on the frame being sent.
- R9: Clearing `xmit_on` partway through a frame abandons it. After `xmit_on` returns to 1, the line is at mark and `byte_rdy` is 1, and no remaining bits of the old frame appear.
- R10: Setting `gp_level` to 0 and then clearing `xmit_on` holds `line_o` at 0 with `line_oe` = 1, for as long as both bits keep those values, no matter how many ticks arrive.
- R11: After `xmit_on` rises, the bit counter starts from zero. The start bit of the first new frame lasts the full 16 ticks, even if the previous frame was abandoned partway through a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xmit_on | input | 1 | Transmitter enable; 0 resets the transmitter and hands the line to the port |
| gp_dir | input | 1 | Port direction, 1 = drive the line while the transmitter is off |
| gp_level | input | 1 | Port level driven while the transmitter is off |
| os_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| par_on | input | 1 | Append a parity bit |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| stop2 | input | 1 | 1 = two stop bits |
| byte_vld | input | 1 | Byte offered |
| byte_dat | input | 8 | Byte to send |
| byte_rdy | output | 1 | Byte can be taken this cycle |
| line_o | output | 1 | Serial line level |
| line_oe | output | 1 | Serial line output enable |

## Verification
The hardest case to reach is a frame abandoned partway through a bit, with the tick counter holding a partial count, followed by a restart. To get there, the stimulus sends three bits plus five ticks of a frame and switches the transmitter off with the port level already at 0. It then holds that break across many ticks and switches the transmitter back on. The first start bit of the next frame is timed tick by tick: a counter that kept its old count would end that start bit early, and the bench would see the wrong level after the fifteenth tick.

// File: rtl/brkx_uart_pkg.sv
// Package: shared widths and frame configuration type for the transmitter.
// Assumes one start bit, a fixed data width and at most two stop bits.
package brkx_uart_pkg;
    localparam int DATA_W  = 8;
    localparam int OVS     = 16;
    localparam int FRM_MAX = DATA_W + 4;

    typedef struct packed {
        logic par_on;
        logic par_odd;
        logic stop2;
    } frm_cfg_t;
endpackage

// File: rtl/brkx_os_count.sv
// Oversample counter: counts tick pulses inside one frame bit and flags the
// pulse that ends the bit. Assumes clr dominates and zeroes the count.
module brkx_os_count #(
    parameter int OVS = 16,
    localparam int CW = $clog2(OVS)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    input  logic tick,
    output logic bit_end
);
    logic [CW-1:0] cnt;

    // Count ticks while a frame runs; wrap at the bit boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt <= '0;
        else if (run && tick)
            cnt <= (cnt == CW'(OVS-1)) ? '0 : cnt + 1'b1;
    end

    // Flag the last tick of the current bit.
    always_comb bit_end = run && tick && !clr && (cnt == CW'(OVS-1));

    a_r11_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));
    a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(cnt));
endmodule

// File: rtl/brkx_frame_shift.sv
// Frame shifter: builds the start/data/parity/stop vector when a byte is
// loaded and steps it out LSB first, one bit per bit_end. Assumes en low
// is a synchronous clear that wins over load and bit_end.
module brkx_frame_shift
    import brkx_uart_pkg::*;
#(
    parameter int DW = DATA_W,
    localparam int FW = DW + 4,
    localparam int LW = $clog2(FW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          load,
    input  logic [DW-1:0] dat,
    input  frm_cfg_t      cfg,
    input  logic          bit_end,
    output logic          busy,
    output logic          line_bit
);
    logic [FW-1:0] sh;
    logic [LW-1:0] left;
    logic [FW-1:0] frm;
    logic [LW-1:0] frm_len;
    logic          par_bit;

    // Assemble the frame to be sent from the offered byte and settings.
    always_comb begin
        par_bit = (^dat) ^ cfg.par_odd;
        frm     = '1;
        frm[0]  = 1'b0;
        frm[DW:1] = dat;
        if (cfg.par_on)
            frm[DW+1] = par_bit;
        frm_len = LW'(DW + 2) + LW'(cfg.par_on) + LW'(cfg.stop2);
    end

    // Load, shift and count down the bits of the frame in flight.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            sh   <= '1;
            left <= '0;
            busy <= 1'b0;
        end else if (load) begin
            sh   <= frm;
            left <= frm_len;
            busy <= 1'b1;
        end else if (busy && bit_end) begin
            sh   <= {1'b1, sh[FW-1:1]};
            left <= left - 1'b1;
            busy <= (left != LW'(1));
        end
    end

    // Present the current frame bit, mark when idle.
    always_comb line_bit = busy ? sh[0] : 1'b1;

    a_r9_abort: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !busy);
    a_r4_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !line_bit);
    a_r7_last_is_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && left == LW'(1)) |-> line_bit);
    a_r8_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !load);
endmodule

// File: rtl/brkx_pin_mux.sv
// Pin mux: hands the line to the transmitter while enabled, otherwise to
// the port level and direction bits. Purely combinational.
module brkx_pin_mux (
    input  logic xmit_on,
    input  logic tx_bit,
    input  logic gp_dir,
    input  logic gp_level,
    output logic line_o,
    output logic line_oe
);
    // Select the owner of the line.
    always_comb begin
        line_o  = xmit_on ? tx_bit : gp_level;
        line_oe = xmit_on ? 1'b1   : gp_dir;
    end
endmodule

// File: rtl/brkx_uart_tx.sv
// Top: serial transmitter with port override of the line. Takes a byte
// through a valid/ready handshake only while enabled and idle. Assumes
// os_tick is a single-cycle pulse at 16x the bit rate.
module brkx_uart_tx
    import brkx_uart_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xmit_on,
    input  logic              gp_dir,
    input  logic              gp_level,
    input  logic              os_tick,
    input  logic              par_on,
    input  logic              par_odd,
    input  logic              stop2,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_dat,
    output logic              byte_rdy,
    output logic              line_o,
    output logic              line_oe
);
    logic     busy;
    logic     load;
    logic     bit_end;
    logic     tx_bit;
    frm_cfg_t cfg;

    // Handshake and configuration bundling.
    always_comb begin
        byte_rdy = xmit_on && !busy;
        load     = byte_vld && byte_rdy;
        cfg      = '{par_on: par_on, par_odd: par_odd, stop2: stop2};
    end

    brkx_os_count #(.OVS(OVS)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(!xmit_on || load), .run(busy),
        .tick(os_tick), .bit_end(bit_end)
    );

    brkx_frame_shift #(.DW(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .en(xmit_on), .load(load), .dat(byte_dat),
        .cfg(cfg), .bit_end(bit_end), .busy(busy), .line_bit(tx_bit)
    );

    brkx_pin_mux u_mux (
        .xmit_on(xmit_on), .tx_bit(tx_bit), .gp_dir(gp_dir),
        .gp_level(gp_level), .line_o(line_o), .line_oe(line_oe)
    );

    a_r3_no_ready_off: assert property (@(posedge clk) disable iff (!rst_n)
        !xmit_on |-> !byte_rdy);
    a_r2_idle_mark: assert property (@(posedge clk) disable iff (!rst_n)
        (xmit_on && !busy) |-> (line_o && line_oe));
    a_r1_port_follow: assert property (@(posedge clk) disable iff (!rst_n)
        !xmit_on |-> (line_o == gp_level && line_oe == gp_dir));
endmodule

// File: tb/brkx_uart_tx_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module brkx_uart_tx_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic xmit_on = 1'b0, gp_dir = 1'b0, gp_level = 1'b0, os_tick = 1'b0;
    logic par_on = 1'b0, par_odd = 1'b0, stop2 = 1'b0, byte_vld = 1'b0;
    logic [7:0] byte_dat = 8'h00;
    logic byte_rdy, line_o, line_oe;
    int n_chk = 0, n_bad = 0, cyc = 0;

    always #2 clk = ~clk;

    brkx_uart_tx u_dut (
        .clk(clk), .rst_n(rst_n), .xmit_on(xmit_on), .gp_dir(gp_dir),
        .gp_level(gp_level), .os_tick(os_tick), .par_on(par_on),
        .par_odd(par_odd), .stop2(stop2), .byte_vld(byte_vld),
        .byte_dat(byte_dat), .byte_rdy(byte_rdy), .line_o(line_o),
        .line_oe(line_oe)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog: an overrun counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected <150000", cyc);
            finish_run();
        end
    end

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) os_tick = 1'b1;
            @(negedge clk) os_tick = 1'b0;
        end
    endtask

    // Send one byte and check every bit level and duration (R4-R8).
    task automatic send_check(input logic [7:0] d, input logic p_on,
                              input logic p_odd, input logic s2, input bit poke);
        logic exp_b[12];
        int len;
        for (int i = 0; i < 12; i++) exp_b[i] = 1'b1;
        exp_b[0] = 1'b0;
        for (int i = 0; i < 8; i++) exp_b[i+1] = d[i];
        if (p_on) exp_b[9] = (^d) ^ p_odd;
        len = 10 + p_on + s2;
        par_on = p_on; par_odd = p_odd; stop2 = s2;
        @(negedge clk) begin byte_vld = 1'b1; byte_dat = d; end
        @(negedge clk) byte_vld = 1'b0;
        chk("R8 ready low in frame", byte_rdy, 0);
        for (int b = 0; b < len; b++) begin
            chk($sformatf("R4/R6/R7 bit %0d", b), line_o, exp_b[b]);
            if (poke && b == 2) begin
                @(negedge clk) begin byte_vld = 1'b1; byte_dat = ~d; end
                @(negedge clk) byte_vld = 1'b0;
            end
            ticks(15);
            chk($sformatf("R5 bit %0d held 15 ticks", b), line_o, exp_b[b]);
            ticks(1);
        end
        chk("R7 ready after stop", byte_rdy, 1);
        chk("R2 mark after frame", line_o, 1);
    endtask

    task automatic t_reset_disabled();
        gp_dir = 1'b1; gp_level = 1'b1;
        @(negedge clk);
        chk("R1 level follows port", line_o, 1);
        chk("R1 oe follows dir", line_oe, 1);
        gp_dir = 1'b0; gp_level = 1'b0;
        @(negedge clk);
        chk("R1 oe off", line_oe, 0);
        chk("R1 level low", line_o, 0);
        chk("R3 ready low off", byte_rdy, 0);
    endtask

    task automatic t_valid_ignored_off();
        gp_dir = 1'b1; gp_level = 1'b1;
        @(negedge clk) begin byte_vld = 1'b1; byte_dat = 8'h00; end
        ticks(4);
        chk("R3 ready low with valid", byte_rdy, 0);
        byte_vld = 1'b0;
        @(negedge clk) xmit_on = 1'b1;
        ticks(20);
        chk("R3 no frame after enable", line_o, 1);
        chk("R2 idle ready", byte_rdy, 1);
        chk("R2 idle oe", line_oe, 1);
    endtask

    task automatic t_abort_break_restart();
        par_on = 1'b0; stop2 = 1'b0;
        @(negedge clk) begin byte_vld = 1'b1; byte_dat = 8'h00; end
        @(negedge clk) byte_vld = 1'b0;
        ticks(16*3 + 5);
        chk("R9 mid-frame low data", line_o, 0);
        gp_level = 1'b0;
        @(negedge clk) xmit_on = 1'b0;
        #0;
        chk("R10 break low", line_o, 0);
        chk("R10 break driven", line_oe, 1);
        ticks(40);
        chk("R10 break held", line_o, 0);
        gp_level = 1'b1;
        @(negedge clk) xmit_on = 1'b1;
        @(negedge clk);
        chk("R9 mark after re-enable", line_o, 1);
        chk("R9 ready after re-enable", byte_rdy, 1);
        ticks(32);
        chk("R9 no old bits", line_o, 1);
        send_check(8'hA5, 1'b0, 1'b0, 1'b0, 1'b0); // R11 full start bit
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R3 reset ready", byte_rdy, 0);
        rst_n = 1'b1;
        t_reset_disabled();
        t_valid_ignored_off();
        send_check(8'h35, 1'b0, 1'b0, 1'b0, 1'b1);  // R4 R8 plain frame
        send_check(8'hC1, 1'b1, 1'b0, 1'b0, 1'b0);  // R6 even parity
        send_check(8'h7E, 1'b1, 1'b1, 1'b1, 1'b0);  // R6 odd, R7 two stop
        send_check(8'h80, 1'b0, 1'b0, 1'b1, 1'b0);  // R7 two stop, no parity
        t_abort_break_restart();
        finish_run();
    end
endmodule